// File: doc/BRIEF.md
# Four-Source Vectored Interrupt Controller with Selectable Priority

This block collects interrupt events from four sources and offers the most urgent one to a processor core. Source 1 and source 2 are external active-low pins that raise a request on their falling edge. Source 4 and source 5 are single-cycle event strobes from two timers. Each event latches a bit in a request register. A mask register carries one enable per source plus a global enable. A 4-bit priority code picks one of twelve fixed orderings of the four sources.

When the global enable is set and at least one enabled request is pending, the controller offers the highest-ranked one. It raises `irq_valid` and drives the low address of that source's two-byte vector slot. The core takes the offer by pulsing `irq_ack`. In the same clock edge the controller clears the taken request bit and the global enable. Nothing further is offered until software sets the global enable again. With the global enable or the individual enables cleared, events still latch, so software can poll and clear the request register through the configuration port.

The control path is a three-state machine:
- `ST_IDLE`: waits for an enabled pending request. `IDLE->OFFER` when one exists.
- `ST_OFFER`: presents the current winner. `OFFER->TAKEN` on a grant. `OFFER->IDLE` when no enabled request remains (a withdrawal).
- `ST_TAKEN`: a one-cycle settle after a grant. `TAKEN->IDLE` always.

Top module: `irqc_top`

## Requirements
- R1: After reset, the request register, the mask register and the priority code read 0, and `irq_valid` is low.
- R2: A falling edge on `pin_a_n` sets request bit 1, and a falling edge on `pin_b_n` sets request bit 2. With `SYNC_STAGES`=2, the bit reads 1 after the third rising clock edge following the pin going low. A rising edge sets nothing.
- R3: A high on `tmr0_evt` at a clock edge sets request bit 4 at that edge. A high on `tmr1_evt` does the same for request bit 5.
- R4: Writes go through `cfg_wr` with `cfg_sel` selecting the target: 0 for requests, 1 for mask, 2 for priority code. The priority code takes `cfg_wdata[3:0]`. The request register keeps only bits 1, 2, 4 and 5. The mask keeps bits 1, 2, 4 and 5 (per-source enables) and bit 7 (global enable). All other bits read 0.
- R5: While mask bit 7 is 1 and a request is pending with its mask bit set, the state machine enters `ST_OFFER` one edge later. `irq_valid` is then high, and `irq_vector` is 2, 4, 8 or 10 for source 1, 2, 4 or 5 respectively.
- R6: The offered source is the highest-ranked pending enabled one, under these codes: 0001 1>4>5>2, 0011 4>1>5>2, 0100 5>2>1>4, 0101 5>1>4>2, 0110 5>2>4>1, 0111 5>4>1>2, 1000 2>1>4>5, 1001 1>4>2>5, 1010 2>4>1>5, 1011 4>1>2>5, 1100 2>5>1>4, 1110 2>5>4>1.
- R7: Codes 0000, 0010, 1101 and 1111 are reserved. Under them, `irq_valid` stays low whatever is pending.
- R8: `irq_ack` high while `irq_valid` is high is a grant. At that edge it clears the offered request bit and mask bit 7, and `irq_valid` is low in the following cycle.
- R9: With mask bit 7 clear, events still latch in the request register and `irq_valid` stays low.
- R10: A request-register write in the same cycle as a hardware event leaves the event's bit set and writes the other bits as given.
- R11: While offering, `irq_vector` follows the current winner, so a newly arrived higher-ranked request takes over. Clearing the global enable drops `irq_valid` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_a_n | input | 1 | External request pin for source 1, falling-edge active |
| pin_b_n | input | 1 | External request pin for source 2, falling-edge active |
| tmr0_evt | input | 1 | Timer 0 event strobe, source 4 |
| tmr1_evt | input | 1 | Timer 1 event strobe, source 5 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 requests, 1 mask, 2 priority code |
| cfg_wdata | input | 8 | Write data |
| req_rd | output | 8 | Request register contents |
| mask_rd | output | 8 | Mask register contents |
| prio_rd | output | 4 | Priority code |
| irq_valid | output | 1 | An interrupt is being offered |
| irq_vector | output | 8 | Low address of the offered vector slot (0 when idle) |
| irq_ack | input | 1 | Grant from the core |

## Verification
Corruption of the request register shows on `req_rd` one edge after the faulty event. It also shows as a wrong or missing offer on the next enabled grant. A wrong priority decode shows as a wrong `irq_vector` on the first grant of a sequence with all four sources pending. A stuck state machine shows as `irq_valid` either failing to rise one edge after the global enable is set, or failing to fall after a grant. The grant side effects show on `mask_rd` bit 7 and `req_rd` at the negative edge after the grant.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC    = 4;
    localparam int REG_W   = 8;
    localparam int GIE_BIT = 7;

    localparam logic [REG_W-1:0] REQ_KEEP  = 8'h36;
    localparam logic [REG_W-1:0] MASK_KEEP = 8'hB6;

    localparam logic [1:0] SEL_REQ  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_PRIO = 2'd2;

    typedef logic [1:0] src_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_TAKEN = 2'd2
    } ctl_state_e;

    // register bit position of each source index
    function automatic int src_pos(int s);
        case (s)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] src_bit(src_t s);
        case (s)
            2'd0:    return 8'h02;
            2'd1:    return 8'h04;
            2'd2:    return 8'h10;
            default: return 8'h20;
        endcase
    endfunction

    function automatic logic [7:0] src_vec(src_t s);
        case (s)
            2'd0:    return 8'd2;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd10;
        endcase
    endfunction

    // {usable, rank0 .. rank3}, rank0 highest; index 0=src1 1=src2 2=src4 3=src5
    function automatic logic [8:0] order_of(logic [3:0] code);
        case (code)
            4'b0001: return {1'b1, 2'd0, 2'd2, 2'd3, 2'd1};
            4'b0011: return {1'b1, 2'd2, 2'd0, 2'd3, 2'd1};
            4'b0100: return {1'b1, 2'd3, 2'd1, 2'd0, 2'd2};
            4'b0101: return {1'b1, 2'd3, 2'd0, 2'd2, 2'd1};
            4'b0110: return {1'b1, 2'd3, 2'd1, 2'd2, 2'd0};
            4'b0111: return {1'b1, 2'd3, 2'd2, 2'd0, 2'd1};
            4'b1000: return {1'b1, 2'd1, 2'd0, 2'd2, 2'd3};
            4'b1001: return {1'b1, 2'd0, 2'd2, 2'd1, 2'd3};
            4'b1010: return {1'b1, 2'd1, 2'd2, 2'd0, 2'd3};
            4'b1011: return {1'b1, 2'd2, 2'd0, 2'd1, 2'd3};
            4'b1100: return {1'b1, 2'd1, 2'd3, 2'd0, 2'd2};
            4'b1110: return {1'b1, 2'd1, 2'd3, 2'd2, 2'd0};
            default: return 9'd0;
        endcase
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R2

endmodule

// File: rtl/irqc_reqfile.sv
module irqc_reqfile
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hw_set,
    input  logic [REG_W-1:0] grant_clr,
    input  logic             sw_wr,
    input  logic [REG_W-1:0] sw_data,
    output logic [REG_W-1:0] req_q
);
    logic [REG_W-1:0] req_d;

    always_comb begin
        if (sw_wr) req_d = sw_data & REQ_KEEP;
        else       req_d = req_q & ~grant_clr;
        req_d = req_d | (hw_set & REQ_KEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((req_q & $past(hw_set)) == $past(hw_set))); // R10
    AST_CLR_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_clr)); // R8

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [3:0]      code,
    input  logic [NSRC-1:0] pend,
    output logic            win_valid,
    output src_t            win_src,
    output logic            reserved
);
    logic [8:0] ord;
    src_t       cand;

    always_comb begin
        ord       = order_of(code);
        reserved  = ~ord[8];
        win_valid = 1'b0;
        win_src   = 2'd0;
        cand      = 2'd0;
        for (int r = 0; r < NSRC; r++) begin
            cand = ord[7-2*r -: 2];
            if (!win_valid && ord[8] && pend[cand]) begin
                win_valid = 1'b1;
                win_src   = cand;
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a_n,
    input  logic       pin_b_n,
    input  logic       tmr0_evt,
    input  logic       tmr1_evt,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] req_rd,
    output logic [7:0] mask_rd,
    output logic [3:0] prio_rd,
    output logic       irq_valid,
    output logic [7:0] irq_vector,
    input  logic       irq_ack
);
    localparam int NPIN = 2;

    logic [NPIN-1:0]  pins_n;
    logic [NPIN-1:0]  fall;
    logic [REG_W-1:0] hw_set;
    logic [REG_W-1:0] grant_clr;
    logic [REG_W-1:0] req_q;
    logic [REG_W-1:0] mask_q, mask_d;
    logic [3:0]       prio_q;
    logic [NSRC-1:0]  pend_en;
    logic             win_valid;
    src_t             win_src;
    logic             rsv;
    logic             grant;
    ctl_state_e       state_q, state_d;

    assign pins_n = {pin_b_n, pin_a_n};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        irqc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pins_n[g]),
            .fall  (fall[g])
        );
    end

    always_comb begin
        hw_set              = '0;
        hw_set[src_pos(0)]  = fall[0];
        hw_set[src_pos(1)]  = fall[1];
        hw_set[src_pos(2)]  = tmr0_evt;
        hw_set[src_pos(3)]  = tmr1_evt;
    end

    irqc_reqfile u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set    (hw_set),
        .grant_clr (grant_clr),
        .sw_wr     (cfg_wr && cfg_sel == SEL_REQ),
        .sw_data   (cfg_wdata),
        .req_q     (req_q)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        assign pend_en[g] = req_q[src_pos(g)] & mask_q[src_pos(g)] & mask_q[GIE_BIT];
    end

    irqc_prio u_prio (
        .code      (prio_q),
        .pend      (pend_en),
        .win_valid (win_valid),
        .win_src   (win_src),
        .reserved  (rsv)
    );

    // mask and priority registers
    always_comb begin
        mask_d = mask_q;
        if (cfg_wr && cfg_sel == SEL_MASK) mask_d = cfg_wdata & MASK_KEEP;
        if (grant) mask_d[GIE_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            prio_q <= '0;
        end else begin
            mask_q <= mask_d;
            if (cfg_wr && cfg_sel == SEL_PRIO) prio_q <= cfg_wdata[3:0];
        end
    end

    // control state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_valid) state_d = ST_OFFER;
            ST_OFFER: begin
                if (grant)           state_d = ST_TAKEN;
                else if (!win_valid) state_d = ST_IDLE;
            end
            ST_TAKEN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control state machine: outputs
    always_comb begin
        irq_valid  = 1'b0;
        irq_vector = 8'h00;
        grant      = 1'b0;
        grant_clr  = '0;
        unique case (state_q)
            ST_OFFER: begin
                irq_valid  = win_valid;
                irq_vector = win_valid ? src_vec(win_src) : 8'h00;
                grant      = win_valid && irq_ack;
                grant_clr  = grant ? src_bit(win_src) : '0;
            end
            ST_IDLE, ST_TAKEN: ;
            default: ;
        endcase
    end

    assign req_rd  = req_q;
    assign mask_rd = mask_q;
    assign prio_rd = prio_q;

    AST_OFFER_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> mask_q[GIE_BIT]); // R5
    AST_GRANT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> (!mask_q[GIE_BIT] && !irq_valid)); // R8
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |-> !irq_valid); // R7
    AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKEN) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_a_n = 1'b1, pin_b_n = 1'b1;
    logic       tmr0_evt = 1'b0, tmr1_evt = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] req_rd, mask_rd;
    logic [3:0] prio_rd;
    logic       irq_valid;
    logic [7:0] irq_vector;
    logic       irq_ack = 1'b0;

    int n_chk = 0, n_fail = 0, grants = 0;
    bit mon_on = 1'b0, done = 1'b0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
        .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_rd(req_rd),
        .mask_rd(mask_rd), .prio_rd(prio_rd), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_ack(irq_ack)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic fall_a();
        @(negedge clk); pin_a_n = 1'b0;
        repeat (4) @(negedge clk);
        pin_a_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fall_b();
        @(negedge clk); pin_b_n = 1'b0;
        repeat (4) @(negedge clk);
        pin_b_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick0();
        @(negedge clk); tmr0_evt = 1'b1;
        @(negedge clk); tmr0_evt = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk); tmr1_evt = 1'b1;
        @(negedge clk); tmr1_evt = 1'b0;
    endtask

    // driver: load all four requests, push expected vectors, release one grant at a time
    task automatic run_order(logic [3:0] code, int e0, int e1, int e2, int e3);
        int exp_v[4];
        exp_v = '{e0, e1, e2, e3};
        wr(2'd2, {4'h0, code});
        wr(2'd1, 8'h36);
        fall_a(); fall_b(); tick0(); tick1();
        chk("R9 polled latch", req_rd, 8'h36);
        chk("R9 no offer", irq_valid, 1'b0);
        for (int i = 0; i < 4; i++) exp_q.push_back(exp_v[i]);
        mon_on = 1'b1;
        for (int i = 0; i < 4; i++) begin
            int g;
            g = grants;
            wr(2'd1, 8'hB6);
            wait (grants == g + 1);
            chk("R8 gie cleared", mask_rd[7], 1'b0);
        end
        chk("R8 all served", req_rd, 8'h00);
        chk("R6 queue drained", exp_q.size(), 0);
        mon_on = 1'b0;
        wr(2'd1, 8'h00);
    endtask

    // monitor: compare offered vector against the scoreboard and grant it
    initial begin
        forever begin
            @(negedge clk);
            if (irq_ack) begin
                irq_ack = 1'b0;
                grants++;
            end else if (mon_on && irq_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected offer", irq_vector, 8'hFF);
                end else begin
                    chk("R6 R5 vector order", irq_vector, exp_q.pop_front());
                end
                irq_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req reset", req_rd, 8'h00);
        chk("R1 mask reset", mask_rd, 8'h00);
        chk("R1 prio reset", prio_rd, 4'h0);
        chk("R1 valid reset", irq_valid, 1'b0);

        // R2 latency and rising edge ignored
        @(negedge clk); pin_a_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet", req_rd, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R2 pin a sets bit1", req_rd, 8'h02);
        wr(2'd0, 8'h00);
        @(negedge clk); pin_a_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 rising ignored", req_rd, 8'h00);
        fall_b();
        chk("R2 pin b sets bit2", req_rd, 8'h04);
        wr(2'd0, 8'h00);

        // R3 timers
        @(negedge clk); tmr0_evt = 1'b1;
        @(negedge clk); tmr0_evt = 1'b0;
        chk("R3 timer0 bit4", req_rd, 8'h10);
        tick1();
        chk("R3 timer1 bit5", req_rd, 8'h30);
        wr(2'd0, 8'h00);

        // R4 kept bits
        wr(2'd0, 8'hFF);
        chk("R4 req kept bits", req_rd, 8'h36);
        wr(2'd1, 8'hFF);
        chk("R4 mask kept bits", mask_rd, 8'hB6);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFF);
        chk("R4 prio low nibble", prio_rd, 4'hF);

        // R7 reserved codes
        wr(2'd2, 8'h02);
        tick0();
        wr(2'd1, 8'hB6);
        repeat (3) @(negedge clk);
        chk("R7 code 0010 silent", irq_valid, 1'b0);
        wr(2'd2, 8'h0F);
        repeat (3) @(negedge clk);
        chk("R7 code 1111 silent", irq_valid, 1'b0);
        wr(2'd2, 8'h0B);
        @(negedge clk);
        chk("R5 offer after valid code", irq_valid, 1'b1);
        chk("R5 vector source4", irq_vector, 8'd8);

        // R11 takeover by higher-ranked source, then withdrawal
        wr(2'd2, 8'h01);
        fall_a();
        chk("R11 takeover vector", irq_vector, 8'd2);
        wr(2'd1, 8'h36);
        chk("R11 withdraw", irq_valid, 1'b0);
        chk("R9 requests kept", req_rd, 8'h12);

        // R10 write vs hardware event
        wr(2'd0, 8'h00);
        tick1();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h00; tmr0_evt = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; tmr0_evt = 1'b0;
        chk("R10 event survives write", req_rd, 8'h10);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);

        // R6 orderings with all four pending
        run_order(4'b0001, 2, 8, 10, 4);
        run_order(4'b1110, 4, 10, 8, 2);
        run_order(4'b0100, 10, 4, 2, 8);
        run_order(4'b1011, 8, 2, 4, 10);

        repeat (3) @(negedge clk);
        report();
    end
endmodule